// File: doc/BRIEF.md
# Lane Write Strobe and Bus Drive Control

This block sits between the registered control inputs of an 18-bit common-I/O synchronous SRAM and its storage array. The data word is split into two 9-bit lanes. Each cycle the block turns the sampled global-write, byte-write-enable and per-lane select inputs into per-lane write strobes. It also raises a capture enable for the input data register and decides whether the shared data bus may drive read data.

The address sequencer gives the kind of the current cycle: idle (deselected), start of a new access, burst advance, or burst hold. On a start cycle a separate flag tells whether the processor strobe or the controller strobe opened the access. The asynchronous output enable gates the bus drive combinationally. Two one-bit history registers record whether the previous cycle was idle and whether a write left the bus in high-Z.

Top module: `lane_wr_ctl`

## Requirements
- R1: On a write-eligible cycle with `all_wr_n` low, both bits of `lane_we` are 1, whatever `byte_wr_n` and `lane_sel_n` hold. A write-eligible cycle is any non-idle cycle that is not a processor-opened start.
- R2: On a write-eligible cycle with `all_wr_n` high and `byte_wr_n` low, `lane_we[i]` is 1 exactly when `lane_sel_n[i]` is 0. Bit 0 is lane A (data bits 8:0) and bit 1 is lane B (data bits 17:9).
- R3: With `all_wr_n` high and `byte_wr_n` high, `lane_we` is 0, and the cycle behaves as a read whatever the selects are.
- R4: On a start cycle (`cyc_kind` = 2'b01) with `from_proc` = 1, `lane_we` is 0 for every write-input pattern.
- R5: On a start cycle with `from_proc` = 0, the write inputs take effect in that same cycle, following R1 and R2.
- R6: `din_capture` is 1 exactly when any `lane_we` bit is 1. In such a cycle `bus_drive` is 0 even if `oe_n` is low.
- R7: In a non-idle cycle that writes no lane, `bus_drive` follows `oe_n` combinationally in the same cycle (1 when `oe_n` is 0, else 0). R8 and R9 are the exceptions.
- R8: On a start cycle whose previous cycle was idle (`cyc_kind` = 2'b00), or that is the first cycle after reset, `bus_drive` is 0.
- R9: After a cycle that wrote a lane, every directly following hold cycle (`cyc_kind` = 2'b11) has `bus_drive` 0. A start or advance (`cyc_kind` = 2'b10) cycle ends this.
- R10: In an idle cycle, `lane_we` is 0 and `bus_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| all_wr_n | input | 1 | Sampled global write, active low |
| byte_wr_n | input | 1 | Sampled byte-write enable, active low |
| lane_sel_n | input | LANES | Sampled per-lane selects, active low |
| cyc_kind | input | 2 | Cycle kind: 00 idle, 01 start, 10 advance, 11 hold |
| from_proc | input | 1 | On a start cycle, 1 if the processor strobe opened it |
| oe_n | input | 1 | Asynchronous output enable, active low |
| lane_we | output | LANES | Per-lane write strobes to the array |
| din_capture | output | 1 | Enable for the input data register |
| bus_drive | output | 1 | Output-driver enable for the shared data bus |

## Verification
The assertions assume that `cyc_kind` and `from_proc` come from a well-behaved sequencer. `from_proc` is read only on start cycles, and `cyc_kind` is settled in each cycle before the outputs are judged. The one-cycle history properties also assume that the inputs stay stable between the driving edge and the next rising edge. The stimulus changes every input only on the falling edge. It sweeps all 256 combinations of the inputs in two bit orders, so idle-to-start transitions and write-to-hold runs both occur. A pseudo-random walk and short directed sequences then cover the remaining history cases.

// File: rtl/lane_wr_ctl.sv
module lane_wr_ctl #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             all_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic [1:0]       cyc_kind,
  input  logic             from_proc,
  input  logic             oe_n,
  output logic [LANES-1:0] lane_we,
  output logic             din_capture,
  output logic             bus_drive
);
  localparam logic [1:0] CK_IDLE  = 2'b00;
  localparam logic [1:0] CK_START = 2'b01;
  localparam logic [1:0] CK_NEXT  = 2'b10;
  localparam logic [1:0] CK_HOLD  = 2'b11;

  logic [LANES-1:0] req;
  logic idle_q, hiz_q;

  wire active    = cyc_kind != CK_IDLE;
  wire wr_window = active && !(cyc_kind == CK_START && from_proc);

  always_comb begin
    if (!all_wr_n)       req = '1;
    else if (!byte_wr_n) req = ~lane_sel_n;
    else                 req = '0;
  end

  assign lane_we     = wr_window ? req : '0;
  assign din_capture = |lane_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      hiz_q  <= 1'b0;
    end else begin
      idle_q <= !active;
      hiz_q  <= din_capture || (hiz_q && cyc_kind == CK_HOLD);
    end
  end

  wire oe_masked = cyc_kind == CK_START && idle_q;
  wire hiz_hold  = cyc_kind == CK_HOLD && hiz_q;

  assign bus_drive = active && !din_capture && !oe_n && !oe_masked && !hiz_hold;

  wire unused_next = cyc_kind == CK_NEXT;
endmodule

// File: rtl/lane_wr_ctl_chk.sv
module lane_wr_ctl_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             all_wr_n,
  input logic [1:0]       cyc_kind,
  input logic             from_proc,
  input logic             oe_n,
  input logic [LANES-1:0] lane_we,
  input logic             din_capture,
  input logic             bus_drive
);
  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R4
  proc_start_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 2'b01 && from_proc) |-> lane_we == '0);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 2'b00) |-> (lane_we == '0 && !bus_drive));

  // R6
  wr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    din_capture |-> !bus_drive);

  // R7
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !bus_drive);

  // R1
  gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_wr_n && cyc_kind != 2'b00 && !(cyc_kind == 2'b01 && from_proc)) |-> (&lane_we));

  // R8
  first_rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(cyc_kind) == 2'b00 && cyc_kind == 2'b01) |-> !bus_drive);

  // R9
  hold_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(din_capture) && cyc_kind == 2'b11) |-> !bus_drive);
endmodule

bind lane_wr_ctl lane_wr_ctl_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .all_wr_n(all_wr_n), .cyc_kind(cyc_kind),
  .from_proc(from_proc), .oe_n(oe_n), .lane_we(lane_we),
  .din_capture(din_capture), .bus_drive(bus_drive)
);

// File: tb/test_lane_wr_ctl.sv
`timescale 1ns/1ps
module test_lane_wr_ctl;
  logic clk = 0, rst_n = 0;
  logic all_wr_n = 1, byte_wr_n = 1, from_proc = 0, oe_n = 1;
  logic [1:0] lane_sel_n = 2'b11, cyc_kind = 2'b00;
  logic [1:0] lane_we;
  logic din_capture, bus_drive;
  int checks = 0, errors = 0;
  logic m_idle = 1, m_hiz = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lane_wr_ctl #(.LANES(2)) i_lane_wr_ctl (
    .clk(clk), .rst_n(rst_n), .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n),
    .lane_sel_n(lane_sel_n), .cyc_kind(cyc_kind), .from_proc(from_proc),
    .oe_n(oe_n), .lane_we(lane_we), .din_capture(din_capture), .bus_drive(bus_drive)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] k, input logic p, input logic g,
                      input logic b, input logic [1:0] s, input logic o);
    logic act, win, d;
    logic [1:0] req, ew;
    string wt, dt;
    @(negedge clk);
    cyc_kind = k; from_proc = p; all_wr_n = g; byte_wr_n = b; lane_sel_n = s; oe_n = o;
    #1;
    act = k != 2'b00;
    win = act && !(k == 2'b01 && p);
    req = !g ? 2'b11 : (!b ? ~s : 2'b00);
    ew  = win ? req : 2'b00;
    if (!act) wt = "R10";
    else if (k == 2'b01 && p) wt = "R4";
    else if (!g) wt = "R1";
    else if (!b) wt = (k == 2'b01) ? "R5" : "R2";
    else wt = "R3";
    d = act && ew == 0 && !o && !(k == 2'b01 && m_idle) && !(k == 2'b11 && m_hiz);
    if (!act) dt = "R10";
    else if (ew != 0) dt = "R6";
    else if (o) dt = "R7";
    else if (k == 2'b01 && m_idle) dt = "R8";
    else if (k == 2'b11 && m_hiz) dt = "R9";
    else dt = "R7";
    chk({wt, " lane_we"}, lane_we, ew);
    chk({dt, " bus_drive"}, {1'b0, bus_drive}, {1'b0, d});
    chk("R6 din_capture", {1'b0, din_capture}, {1'b0, |ew});
    m_idle = !act;
    m_hiz  = (|ew) || (m_hiz && k == 2'b11);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset lane_we", lane_we, 2'b00);
    chk("R10 reset bus_drive", {1'b0, bus_drive}, 2'b00);
    @(negedge clk); rst_n = 1;
    // R8 first start after reset is masked
    step(2'b01, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0);
    step(2'b10, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0);
    // R9 write then holds stay high-Z, advance restores drive
    step(2'b10, 1'b0, 1'b1, 1'b0, 2'b10, 1'b0);
    step(2'b11, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0);
    step(2'b11, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0);
    step(2'b10, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0);
    // R4 and R5 on start cycles
    step(2'b01, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
    step(2'b01, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0);
    for (int i = 0; i < 256; i++)
      step(i[1:0], i[2], i[3], i[4], i[6:5], i[7]);
    for (int i = 0; i < 256; i++)
      step(i[7:6], i[5], i[4], i[3], i[2:1], i[0]);
    lf = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[1:0], lf[2], lf[3] | lf[9], lf[4], lf[6:5], lf[7] & lf[8]);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule